// File: doc/BRIEF.md
# Serial Flash Write-Permission Command Front End

This block is the command front end of a serial flash slave. While chip select is low it counts the rising edges of the serial clock and shifts in one opcode. When chip select returns high it acts on that opcode. It keeps two permission flags. The first is the write-enable latch, which every modifying command needs. The second is a one-shot volatile-write arm, which lets the next status-register write go to the volatile status copy instead of the non-volatile one. A modifying command is either accepted or rejected, and the result is shown by a single-cycle strobe.

All three serial inputs are sampled in the system clock domain through a synchronizer chain of configurable depth. The idle level of the serial clock therefore does not matter, and both common SPI clock polarities work. The serial data output is never driven by any command this block decodes. Address, data and timing phases of the modifying commands belong to the blocks downstream. Those blocks act on the accept strobe and on the opcode and volatile-target flag that travel with it.

Top module: `spi_wen_slave`

## Requirements
- R1: After reset, `wel` and `vol_arm` are 0, and `cmd_accept`, `cmd_reject` and `cmd_to_vol` are 0.
- R2: The opcode is taken most significant bit first from `spi_sdi` on rising `spi_sclk` edges while `spi_cs_n` is low. It is acted on only if exactly 8 rising edges came before `spi_cs_n` rises. With any other count, no output and no flag changes.
- R3: Opcode 0x06 sets `wel` to 1 and clears `vol_arm`.
- R4: Opcode 0x50 sets `vol_arm` to 1 and leaves `wel` unchanged.
- R5: The gated opcodes are 0x02, 0x32, 0x20, 0x52, 0xD8, 0xC7, 0x60, 0x44 and 0x42. When one arrives with `wel` = 1, `cmd_accept` pulses for one cycle with `cmd_opcode` equal to the opcode and `cmd_to_vol` = 0, and both `wel` and `vol_arm` clear.
- R6: A gated opcode that arrives with `wel` = 0 pulses `cmd_reject` for one cycle. `cmd_accept` is not raised, and `wel` and `vol_arm` keep their values.
- R7: Opcode 0x01 with `vol_arm` = 1 is accepted whatever the value of `wel`, with `cmd_to_vol` = 1 in the same cycle as `cmd_accept`. Both flags then clear.
- R8: Opcode 0x01 with `vol_arm` = 0 and `wel` = 1 is accepted with `cmd_to_vol` = 0, and both flags clear. With both flags at 0 it is rejected as in R6.
- R9: Any other opcode clears `vol_arm` and leaves `wel` unchanged, with no strobe.
- R10: Frames are decoded the same way whether `spi_sclk` idles low or high around chip select. A clock already high when chip select falls is not counted as an edge.
- R11: `spi_sdo_oe` stays 0 at all times, so the data output is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out value |
| spi_sdo_oe | output | 1 | Output enable for `spi_sdo` (0 = high impedance) |
| wel | output | 1 | Write-enable latch |
| vol_arm | output | 1 | One-shot volatile status-write arm |
| cmd_accept | output | 1 | One-cycle strobe: a modifying command was accepted |
| cmd_reject | output | 1 | One-cycle strobe: a modifying command was refused |
| cmd_to_vol | output | 1 | With `cmd_accept`: status write goes to the volatile copy |
| cmd_opcode | output | 8 | Opcode of the last accepted command |

## Verification
Every result of a frame becomes due SYNC_STAGES + 1 rising clock edges after `spi_cs_n` rises. That count covers the synchronizer chain, one cycle for edge detection and the registered decision. The bench drives the pins on falling edges, waits exactly that number of rising edges and samples at the falling edge after them. This is the cycle in which the strobes are high, and the flags have already settled. The bench samples the strobes once more one cycle later to confirm they last a single cycle. The sweep sets up each of the four flag states before sending each of the 256 opcodes, and the clock idle level alternates from one opcode to the next.

// File: rtl/spi_wen_pkg.sv
package spi_wen_pkg;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OP_SET_WEL  = 8'h06;
   localparam logic [OPC_W-1:0] OP_ARM_VOL  = 8'h50;
   localparam logic [OPC_W-1:0] OP_STAT_WR  = 8'h01;

   typedef struct packed {
      logic wel;
      logic arm;
   } perm_t;

   typedef struct packed {
      logic             accept;
      logic             reject;
      logic             to_vol;
      logic [OPC_W-1:0] opcode;
   } verdict_t;

   // Opcodes that modify storage and need the write-enable latch.
   function automatic logic op_needs_wel(input logic [OPC_W-1:0] op);
      logic hit;
      case (op)
         8'h02, 8'h32, 8'h20, 8'h52, 8'hD8,
         8'hC7, 8'h60, 8'h44, 8'h42: hit = 1'b1;
         default:                    hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/spi_wen_shift.sv
module spi_wen_shift
   import spi_wen_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic             sdi,
   output logic             frame_end,
   output logic             frame_ok,
   output logic [OPC_W-1:0] opcode
);

   localparam int                MAX_CNT = OPC_W + 1;
   localparam int                CNT_W   = $clog2(MAX_CNT + 1);
   localparam logic [2:0]        IDLE_V  = 3'b100;

   logic [2:0]       pin_s;
   logic             s_cs, s_sclk, s_sdi;
   logic             p_cs, p_sclk;
   logic             sclk_rise;
   logic [CNT_W-1:0] bit_cnt;
   logic [OPC_W-1:0] shreg;

   generate
      if (SYNC_STAGES > 6) begin : g_bad_depth
         $error("spi_wen_shift: SYNC_STAGES must be 0..6");
      end

      if (SYNC_STAGES == 0) begin : g_direct
         assign pin_s = {cs_n, sclk, sdi};
      end else begin : g_sync
         logic [2:0] chain [SYNC_STAGES];
         for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[k] <= IDLE_V;
                  else        chain[k] <= {cs_n, sclk, sdi};
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[k] <= IDLE_V;
                  else        chain[k] <= chain[k-1];
               end
            end
         end
         assign pin_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign {s_cs, s_sclk, s_sdi} = pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_cs   <= 1'b1;
         p_sclk <= 1'b0;
      end else begin
         p_cs   <= s_cs;
         p_sclk <= s_sclk;
      end
   end

   assign sclk_rise = s_sclk & ~p_sclk & ~s_cs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (s_cs) begin
         bit_cnt <= '0;
      end else if (sclk_rise) begin
         shreg <= {shreg[OPC_W-2:0], s_sdi};
         if (bit_cnt != CNT_W'(MAX_CNT)) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign frame_end = s_cs & ~p_cs;
   assign frame_ok  = (bit_cnt == CNT_W'(OPC_W));
   assign opcode    = shreg;

   // R2: a deselected interval always leaves the edge count empty.
   a_r2_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      p_cs |-> (bit_cnt == '0));

   // R2: the count never passes its saturation point.
   a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bit_cnt == CNT_W'(MAX_CNT)) && !p_cs |-> (bit_cnt == CNT_W'(MAX_CNT)));

endmodule

// File: rtl/spi_wen_perm.sv
module spi_wen_perm
   import spi_wen_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_end,
   input  logic             frame_ok,
   input  logic [OPC_W-1:0] opcode,
   output perm_t            perm,
   output verdict_t         verdict
);

   perm_t    perm_d;
   verdict_t verdict_d;
   logic     exec;
   logic     is_stat_wr;
   logic     is_gated;

   assign exec       = frame_end & frame_ok;
   assign is_stat_wr = (opcode == OP_STAT_WR);
   assign is_gated   = op_needs_wel(opcode);

   always_comb begin
      perm_d            = perm;
      verdict_d         = '0;
      verdict_d.opcode  = verdict.opcode;
      if (exec) begin
         if (is_stat_wr) begin
            if (perm.arm || perm.wel) begin
               verdict_d.accept = 1'b1;
               verdict_d.to_vol = perm.arm;
               verdict_d.opcode = opcode;
               perm_d           = '0;
            end else begin
               verdict_d.reject = 1'b1;
            end
         end else if (is_gated) begin
            if (perm.wel) begin
               verdict_d.accept = 1'b1;
               verdict_d.opcode = opcode;
               perm_d           = '0;
            end else begin
               verdict_d.reject = 1'b1;
            end
         end else if (opcode == OP_SET_WEL) begin
            perm_d.wel = 1'b1;
            perm_d.arm = 1'b0;
         end else if (opcode == OP_ARM_VOL) begin
            perm_d.arm = 1'b1;
         end else begin
            perm_d.arm = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perm    <= '0;
         verdict <= '0;
      end else begin
         perm    <= perm_d;
         verdict <= verdict_d;
      end
   end

   // R6: accept and reject never appear together.
   a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({verdict.accept, verdict.reject}));

   // R5: an accepted command leaves no permission behind.
   a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
      verdict.accept |-> (perm == '0));

   // R7: a volatile-target write needs the arm in the cycle before.
   a_r7_vol_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      verdict.accept && verdict.to_vol |-> $past(perm.arm));

   // R6: refusal only happens when the latch was clear.
   a_r6_reject_no_wel: assert property (@(posedge clk) disable iff (!rst_n)
      verdict.reject |-> !$past(perm.wel) && $stable(perm));

   // R4: arming the volatile path never touches the latch.
   a_r4_arm_keeps_wel: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(perm.arm) |-> $stable(perm.wel));

   // R3: setting the latch drops any volatile arm.
   a_r3_wel_drops_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(perm.wel) |-> !perm.arm);

endmodule

// File: rtl/spi_wen_slave.sv
module spi_wen_slave
   import spi_wen_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spi_cs_n,
   input  logic             spi_sclk,
   input  logic             spi_sdi,
   output logic             spi_sdo,
   output logic             spi_sdo_oe,
   output logic             wel,
   output logic             vol_arm,
   output logic             cmd_accept,
   output logic             cmd_reject,
   output logic             cmd_to_vol,
   output logic [OPC_W-1:0] cmd_opcode
);

   logic             frame_end;
   logic             frame_ok;
   logic [OPC_W-1:0] opcode;
   perm_t            perm;
   verdict_t         verdict;

   spi_wen_shift #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (spi_cs_n),
      .sclk      (spi_sclk),
      .sdi       (spi_sdi),
      .frame_end (frame_end),
      .frame_ok  (frame_ok),
      .opcode    (opcode)
   );

   spi_wen_perm u_perm (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .frame_ok  (frame_ok),
      .opcode    (opcode),
      .perm      (perm),
      .verdict   (verdict)
   );

   // None of the decoded commands returns data.
   assign spi_sdo    = 1'b0;
   assign spi_sdo_oe = 1'b0;

   assign wel        = perm.wel;
   assign vol_arm    = perm.arm;
   assign cmd_accept = verdict.accept;
   assign cmd_reject = verdict.reject;
   assign cmd_to_vol = verdict.to_vol;
   assign cmd_opcode = verdict.opcode;

   // R7: the volatile target flag only travels with an accept.
   a_r7_to_vol_with_accept: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_to_vol |-> cmd_accept);

   // R2: a decision needs chip select to have risen.
   a_r2_decide_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_accept || cmd_reject) |-> $past(frame_end));

endmodule

// File: tb/spi_wen_slave_bench.sv
module spi_wen_slave_bench;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int LATENCY    = SYNC + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic       sdo, sdo_oe, wel, vol_arm, acc, rej, to_vol;
   logic [7:0] opc;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_wen_slave #(.SYNC_STAGES(SYNC)) u_spi_wen_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_cs_n   (cs_n),
      .spi_sclk   (sclk),
      .spi_sdi    (sdi),
      .spi_sdo    (sdo),
      .spi_sdo_oe (sdo_oe),
      .wel        (wel),
      .vol_arm    (vol_arm),
      .cmd_accept (acc),
      .cmd_reject (rej),
      .cmd_to_vol (to_vol),
      .cmd_opcode (opc)
   );

   // got/exp layout: {accept, reject, to_vol, wel, arm, sdo_oe}
   task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   function automatic logic [5:0] outs();
      return {acc, rej, to_vol, wel, vol_arm, sdo_oe};
   endfunction

   function automatic bit gated(input logic [7:0] op);
      return op inside {8'h02, 8'h32, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h44, 8'h42};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Sends nbits bits of op (MSB first); ends sampling at the result cycle.
   task automatic send(input logic [7:0] op, input int nbits, input bit mode3);
      @(negedge clk);
      sclk = mode3;
      @(negedge clk);
      cs_n = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         sclk = 1'b0;
         sdi  = (i < 8) ? op[7-i] : 1'b0;
         @(negedge clk);
         sclk = 1'b1;
      end
      @(negedge clk);
      sclk = mode3;
      @(negedge clk);
      cs_n = 1'b1;
      repeat (LATENCY) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      chk("R1 reset state, R11", outs(), 6'b000000);

      // Exhaustive sweep: every opcode from every flag state.
      for (int op = 0; op < 256; op++) begin
         for (int st = 0; st < 4; st++) begin
            logic       w0, a0, ea, er, ev, ew, eaa;
            logic [7:0] o;
            bit         m3;
            string      tag;
            o  = 8'(op);
            w0 = st[1];
            a0 = st[0];
            m3 = o[0];
            do_reset();
            if (w0) send(8'h06, 8, 1'b0);
            if (a0) send(8'h50, 8, 1'b1);
            chk("R3 R4 setup flags", outs() & 6'b000110, {3'b000, w0, a0, 1'b0});
            ea = 0; er = 0; ev = 0; ew = w0; eaa = a0;
            if (o == 8'h01) begin
               tag = "R7 R8";
               if (a0 || w0) begin ea = 1; ev = a0; ew = 0; eaa = 0; end
               else er = 1;
            end else if (gated(o)) begin
               tag = w0 ? "R5" : "R6";
               if (w0) begin ea = 1; ew = 0; eaa = 0; end
               else er = 1;
            end else if (o == 8'h06) begin
               tag = "R3"; ew = 1; eaa = 0;
            end else if (o == 8'h50) begin
               tag = "R4"; eaa = 1;
            end else begin
               tag = "R9"; eaa = 0;
            end
            send(o, 8, m3);
            chk($sformatf("%s R2 R10 mode3=%0d op=%02h st=%0d", tag, m3, o, st),
                outs(), {ea, er, ev, ew, eaa, 1'b0});
            if (ea) begin
               n_chk++;
               if (opc !== o) begin
                  n_fail++;
                  $display("FAIL R5 opcode: got %02h expected %02h", opc, o);
               end
            end
            @(negedge clk);
            chk($sformatf("R5 R6 single-cycle strobe op=%02h", o),
                outs(), {3'b000, ew, eaa, 1'b0});
         end
      end

      // R2: wrong bit counts abort with no change.
      do_reset();
      send(8'h06, 7, 1'b0);
      chk("R2 seven bits of 06", outs(), 6'b000000);
      send(8'h06, 9, 1'b1);
      chk("R2 nine bits of 06", outs(), 6'b000000);
      send(8'h06, 8, 1'b0);
      send(8'h02, 7, 1'b0);
      chk("R2 seven bits of gated op keeps wel", outs(), 6'b000100);
      send(8'h02, 9, 1'b1);
      chk("R2 nine bits of gated op keeps wel", outs(), 6'b000100);
      send(8'h50, 0, 1'b0);
      chk("R2 empty frame", outs(), 6'b000100);

      // R10: idle-high clock at select, same result as idle-low.
      send(8'h50, 8, 1'b1);
      chk("R10 R4 mode3 arm", outs(), 6'b000110);
      send(8'h01, 8, 1'b1);
      chk("R10 R7 mode3 volatile write", outs(), 6'b101000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule